// File: doc/BRIEF.md
# Dual-Speed Issue Port Dispatcher

This block takes a small window of ready micro-operations and hands them to four execution ports in one core cycle. Each candidate arrives with a valid bit, an operation class and an age. Two of the ports run their units at double speed, so each offers a first-half and a second-half slot. The other two ports offer one slot per cycle. That gives six slots in all, and anywhere from zero to six operations can leave in a cycle.

A store is split into two operations before it arrives. The address part uses the store-address port. The data part uses the first half of port 0. Each slot takes only the classes its unit can run. Within a slot the oldest eligible candidate wins. Slots are filled in a fixed order, and a candidate already placed in an earlier slot is skipped by the later ones. Grants, the chosen window indices and the number of grants are all registered, so they appear one clock after the window is presented.

Top module: `dsp_issue_dispatch`

## Requirements
- R1: While `rst` is high at a rising edge, every `slot_grant` bit, every `slot_idx` field and `grant_count` are zero after that edge.
- R2: Class codes are ALU=0, FP move=1, FP/SIMD execute=2, branch=3, load=4, store address=5, store data=6; code 7 is unused. Slot 0 (port 0, first half) accepts classes 0, 1 and 6. Slot 2 (port 0, second half) accepts only class 0.
- R3: Slot 1 (port 1, first half) accepts classes 0, 2 and 3. Slot 3 (port 1, second half) accepts only class 0.
- R4: Slot 4 (load port) accepts only class 4. Slot 5 (store-address port) accepts only class 5. A candidate of class 7 is never granted.
- R5: Among the candidates a slot can take, the one with the largest `cand_age` value wins. On equal ages the lower window index wins.
- R6: Slots are filled in the order 0, 1, 2, 3, 4, 5. A candidate granted to one slot is not offered to later slots, so no candidate holds more than one slot in a cycle.
- R7: `slot_idx` field s (bits s*IDX_W and up) holds the granted window index when `slot_grant[s]` is 1, and is 0 otherwise.
- R8: `grant_count` equals the number of set `slot_grant` bits, in the range 0 to 6.
- R9: A candidate whose `cand_valid` bit is 0 is never granted, whatever its class and age.
- R10: All outputs are registered: they reflect the inputs sampled at the previous rising edge and do not change between edges when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | WIN | One bit per window entry; 1 marks a ready candidate |
| cand_class | input | 3*WIN | Operation class of each entry, entry c in bits 3c+2..3c |
| cand_age | input | AGE_W*WIN | Age of each entry; a larger value means older |
| slot_grant | output | 6 | One bit per slot, slot order as in R2 to R4 |
| slot_idx | output | 6*IDX_W | Window index granted to each slot, slot s in field s |
| grant_count | output | 3 | Number of grants issued in the cycle |

## Verification
The bench builds the block with WIN=8 and AGE_W=4. Eight entries are enough to oversubscribe the double-speed ports: five ALU operations compete for four ALU-capable slots, and several loads and store addresses compete for one slot each. Four-bit ages reach both extremes (0 and 15) and allow deliberate ties, which exercises the lower-index tie rule. The same width lets one vector fill all six slots at once.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int CLS_W     = 3;
  localparam int NUM_SLOTS = 6;

  // Slot numbering is also the fill order.
  localparam int SL_P0_LO = 0;
  localparam int SL_P1_LO = 1;
  localparam int SL_P0_HI = 2;
  localparam int SL_P1_HI = 3;
  localparam int SL_LOAD  = 4;
  localparam int SL_STA   = 5;

  typedef enum logic [CLS_W-1:0] {
    OC_ALU    = 3'd0,
    OC_FPMOV  = 3'd1,
    OC_FPEXE  = 3'd2,
    OC_BRANCH = 3'd3,
    OC_LOAD   = 3'd4,
    OC_STADDR = 3'd5,
    OC_STDATA = 3'd6,
    OC_NONE   = 3'd7
  } op_class_e;

  function automatic logic slot_accepts(input int unsigned slot,
                                        input logic [CLS_W-1:0] cls);
    logic ok;
    ok = 1'b0;
    case (slot)
      SL_P0_LO: ok = (cls == OC_ALU) || (cls == OC_FPMOV) || (cls == OC_STDATA);
      SL_P1_LO: ok = (cls == OC_ALU) || (cls == OC_FPEXE) || (cls == OC_BRANCH);
      SL_P0_HI: ok = (cls == OC_ALU);
      SL_P1_HI: ok = (cls == OC_ALU);
      SL_LOAD:  ok = (cls == OC_LOAD);
      SL_STA:   ok = (cls == OC_STADDR);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dsp_class_decode.sv
module dsp_class_decode
  import dsp_pkg::*;
#(
  parameter int WIN = 8
) (
  input  logic [WIN-1:0]           valid,
  input  logic [CLS_W*WIN-1:0]     cls,
  output logic [NUM_SLOTS*WIN-1:0] elig
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar c = 0; c < WIN; c++) begin : g_cand
      assign elig[s*WIN + c] = valid[c] && slot_accepts(s, cls[c*CLS_W +: CLS_W]);
    end
  end

endmodule

// File: rtl/dsp_oldest_pick.sv
module dsp_oldest_pick #(
  parameter int WIN   = 8,
  parameter int AGE_W = 4,
  parameter int IDX_W = 3
) (
  input  logic [WIN-1:0]       req,
  input  logic [AGE_W*WIN-1:0] age,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  logic [AGE_W-1:0] best;

  // Strict compare keeps the lower index on equal ages.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < WIN; i++) begin
      if (req[i] && (!hit || (age[i*AGE_W +: AGE_W] > best))) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = age[i*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/dsp_grant_count.sv
module dsp_grant_count #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] total
);

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/dsp_issue_dispatch.sv
module dsp_issue_dispatch
  import dsp_pkg::*;
#(
  parameter int WIN   = 8,
  parameter int AGE_W = 4,
  localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIN-1:0]             cand_valid,
  input  logic [CLS_W*WIN-1:0]       cand_class,
  input  logic [AGE_W*WIN-1:0]       cand_age,
  output logic [NUM_SLOTS-1:0]       slot_grant,
  output logic [NUM_SLOTS*IDX_W-1:0] slot_idx,
  output logic [CNT_W-1:0]           grant_count
);

  logic [NUM_SLOTS*WIN-1:0]   elig;
  logic [WIN-1:0]             busy [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]       hit_n;
  logic [NUM_SLOTS*IDX_W-1:0] idx_n;
  logic [CNT_W-1:0]           cnt_n;

  dsp_class_decode #(.WIN(WIN)) u_decode (
    .valid (cand_valid),
    .cls   (cand_class),
    .elig  (elig)
  );

  assign busy[0] = '0;

  // Chain of oldest-first pickers, one per slot, in fill order.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WIN-1:0]   req_s;
    logic             hit_s;
    logic [IDX_W-1:0] idx_s;

    assign req_s = elig[s*WIN +: WIN] & ~busy[s];

    dsp_oldest_pick #(.WIN(WIN), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
      .req (req_s),
      .age (cand_age),
      .hit (hit_s),
      .idx (idx_s)
    );

    assign hit_n[s]              = hit_s;
    assign idx_n[s*IDX_W +: IDX_W] = hit_s ? idx_s : '0;

    if (s + 1 < NUM_SLOTS) begin : g_next
      assign busy[s+1] = busy[s] | (hit_s ? (WIN'(1) << idx_s) : '0);
    end
  end

  dsp_grant_count #(.N(NUM_SLOTS), .CW(CNT_W)) u_count (
    .bits  (hit_n),
    .total (cnt_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_grant  <= '0;
      slot_idx    <= '0;
      grant_count <= '0;
    end else begin
      slot_grant  <= hit_n;
      slot_idx    <= idx_n;
      grant_count <= cnt_n;
    end
  end

  // ---------------- assertions ----------------
  logic [WIN-1:0]   valid_q;
  logic [CLS_W-1:0] class_q [WIN];

  always_ff @(posedge clk) begin
    valid_q <= cand_valid;
    for (int c = 0; c < WIN; c++) begin
      class_q[c] <= cand_class[c*CLS_W +: CLS_W];
    end
  end

  logic dup_grant;
  always_comb begin
    dup_grant = 1'b0;
    for (int a = 0; a < NUM_SLOTS; a++) begin
      for (int b = a + 1; b < NUM_SLOTS; b++) begin
        if (slot_grant[a] && slot_grant[b] &&
            (slot_idx[a*IDX_W +: IDX_W] == slot_idx[b*IDX_W +: IDX_W]))
          dup_grant = 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slot_grant == '0 && grant_count == '0)); // R1

  AST_NO_DUP_GRANT: assert property (@(posedge clk) disable iff (rst)
    !dup_grant); // R6

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    grant_count == CNT_W'($countones(slot_grant))); // R8

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    logic [IDX_W-1:0] out_idx;
    assign out_idx = slot_idx[s*IDX_W +: IDX_W];

    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (rst)
      slot_grant[s] |-> valid_q[out_idx]); // R9

    AST_SLOT_CLASS: assert property (@(posedge clk) disable iff (rst)
      slot_grant[s] |-> slot_accepts(s, class_q[out_idx])); // R2 R3 R4

    AST_IDLE_IDX: assert property (@(posedge clk) disable iff (rst)
      !slot_grant[s] |-> (out_idx == '0)); // R7
  end

endmodule

// File: tb/dsp_issue_dispatch_bench.sv
`timescale 1ns/1ps
module dsp_issue_dispatch_bench;

  localparam int WIN = 8;
  localparam int AW  = 4;
  localparam int NV  = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cand_valid = '0;
  logic [23:0] cand_class = '0;
  logic [31:0] cand_age   = '0;
  logic [5:0]  slot_grant;
  logic [17:0] slot_idx;
  logic [2:0]  grant_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dsp_issue_dispatch #(.WIN(WIN), .AGE_W(AW)) u_dsp_issue_dispatch (
    .clk, .rst, .cand_valid, .cand_class, .cand_age,
    .slot_grant, .slot_idx, .grant_count
  );

  // v0 idle; v1 all six slots (R2 R3 R4 R5 R6); v2 age tie (R5);
  // v3 class 7 and invalid load (R4 R9); v4 older FP move wins slot 0 (R2 R5);
  // v5 FP move cannot use slot 2 (R2); v6 execute/branch only in slot 1 (R3);
  // v7 load/store-address ties (R4 R5); v8 five ALUs for four slots (R6).
  localparam logic [7:0] T_VAL [NV] = '{
    8'h00, 8'hFF, 8'b00100100, 8'b00011101, 8'b00000011,
    8'b00000111, 8'b00000111, 8'b00011111, 8'b00011111 };

  localparam logic [23:0] T_CLS [NV] = '{
    24'd0,
    {3'd2,3'd1,3'd5,3'd4,3'd0,3'd0,3'd0,3'd0},
    {3'd0,3'd0,3'd2,3'd0,3'd0,3'd2,3'd0,3'd0},
    {3'd0,3'd0,3'd0,3'd3,3'd6,3'd4,3'd4,3'd7},
    {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd0},
    {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd0},
    {3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd3,3'd2},
    {3'd0,3'd0,3'd0,3'd4,3'd5,3'd5,3'd4,3'd4},
    24'd0 };

  localparam logic [31:0] T_AGE [NV] = '{
    32'd0,
    {4'd0,4'd0,4'd2,4'd1,4'd7,4'd3,4'd9,4'd5},
    {4'd0,4'd0,4'd4,4'd0,4'd0,4'd4,4'd0,4'd0},
    {4'd0,4'd0,4'd0,4'd6,4'd1,4'd2,4'd14,4'd15},
    {4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd8,4'd2},
    {4'd0,4'd0,4'd0,4'd0,4'd0,4'd1,4'd2,4'd8},
    {4'd0,4'd0,4'd0,4'd0,4'd0,4'd9,4'd5,4'd3},
    {4'd0,4'd0,4'd0,4'd6,4'd3,4'd3,4'd6,4'd1},
    {4'd0,4'd0,4'd0,4'd5,4'd4,4'd3,4'd2,4'd1} };

  localparam logic [5:0] E_GNT [NV] = '{
    6'b000000, 6'b111111, 6'b000010, 6'b010011, 6'b000011,
    6'b000011, 6'b000010, 6'b110000, 6'b001111 };

  localparam logic [17:0] E_IDX [NV] = '{
    18'd0,
    {3'd5,3'd4,3'd2,3'd0,3'd3,3'd1},
    {3'd0,3'd0,3'd0,3'd0,3'd2,3'd0},
    {3'd0,3'd2,3'd0,3'd0,3'd4,3'd3},
    {3'd0,3'd0,3'd0,3'd0,3'd0,3'd1},
    {3'd0,3'd0,3'd0,3'd0,3'd2,3'd0},
    {3'd0,3'd0,3'd0,3'd0,3'd2,3'd0},
    {3'd2,3'd1,3'd0,3'd0,3'd0,3'd0},
    {3'd0,3'd0,3'd1,3'd2,3'd3,3'd4} };

  localparam logic [2:0] E_CNT [NV] = '{
    3'd0, 3'd6, 3'd1, 3'd3, 3'd2, 3'd2, 3'd1, 3'd2, 3'd4 };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int v);
    cand_valid = T_VAL[v];
    cand_class = T_CLS[v];
    cand_age   = T_AGE[v];
  endtask

  initial begin
    // R1: reset with a busy window presented
    drive(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "grant in reset", 32'(slot_grant), 32'd0);
    chk("R1", "idx in reset",   32'(slot_idx),   32'd0);
    chk("R1", "count in reset", 32'(grant_count), 32'd0);

    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      drive(v);
      @(negedge clk);
      chk("R6", $sformatf("grant v%0d", v), 32'(slot_grant),  32'(E_GNT[v]));
      chk("R5", $sformatf("idx v%0d", v),   32'(slot_idx),    32'(E_IDX[v]));
      chk("R8", $sformatf("count v%0d", v), 32'(grant_count), 32'(E_CNT[v]));
    end

    // R10: new inputs do not reach the outputs before the next edge
    drive(1);
    #1;
    chk("R10", "grant held", 32'(slot_grant),  32'(E_GNT[8]));
    chk("R10", "count held", 32'(grant_count), 32'(E_CNT[8]));
    @(negedge clk);
    chk("R10", "grant after edge", 32'(slot_grant),  32'(E_GNT[1]));
    chk("R10", "count after edge", 32'(grant_count), 32'(E_CNT[1]));

    // R1: reset in mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "grant mid reset", 32'(slot_grant),  32'd0);
    chk("R1", "count mid reset", 32'(grant_count), 32'd0);
    rst = 1'b0;

    // R9: invalid entries of every class are ignored
    cand_valid = 8'h00;
    cand_class = T_CLS[1];
    @(negedge clk);
    chk("R9", "grant all invalid", 32'(slot_grant), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule